// File: doc/BRIEF.md
# Complementary Mosaic Luma/Chroma Separator

This block sits behind the digitizer of an interline sensor that carries a complementary-colour mosaic and is read out with vertical pair mixing. Each sample on a line is therefore already a sum of two colours. On one kind of line the samples alternate between green+cyan and magenta+yellow. On the other kind they alternate between magenta+cyan and green+yellow. The block groups the active samples of a line into adjacent pairs. For each pair it emits a luminance value, which is half the pair sum, and a signed colour difference, which is the second sample minus the first. A tag says whether that difference stands for R-Y or for minus (B-Y).

A start-of-line strobe opens each line and carries that line's type bit. Samples flagged as optical black form the black reference. A fixed power-of-two number of them is averaged on each line, and the result becomes the reference at the next line start. The reference is subtracted from both members of a pair before luminance is formed, and luminance is clipped at zero. In the colour difference the reference cancels.

Top module: `mosaic_ycc_sep`

## Requirements
- R1: While reset is held and on the first cycle after it, `vld_o`, `y_o`, `c_o` and `tag_o` are all zero, and the black reference is zero.
- R2: Each active sample (valid and not flagged black) either opens a pair or closes one. Exactly one output with `vld_o`=1 appears in the cycle after a closing sample is accepted, and at no other time.
- R3: `y_o` = max(0, floor((a + b - 2*ref)/2)), where a is the opening sample, b is the closing sample and ref is the black reference in force when the pair closes. The result is 12-bit unsigned.
- R4: `c_o` = b - a as 13-bit two's complement, independent of the black reference. Full-scale inputs give ±4095.
- R5: `tag_o` is the line-type bit captured at the start of the line. 0 means R-Y: the line carries G+Cy then Mg+Ye. 1 means -(B-Y): the line carries Mg+Cy then G+Ye.
- R6: `sol_i` restarts pairing. A sample accepted in the same cycle as `sol_i` opens the first pair of the new line. An unpaired last sample of the previous line is dropped and produces no output.
- R7: A valid sample with `ob_i`=1 produces no output and neither opens nor closes a pair.
- R8: The first 2^OB_LOG2 black samples of a line (16 by default) are summed, including one accepted together with `sol_i`. At the next `sol_i` the sum divided by 2^OB_LOG2 (truncated) becomes the reference. Further black samples are ignored. A line with fewer black samples than that leaves the reference unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 12 | Digitized sample, unsigned |
| smp_vld_i | input | 1 | Sample strobe |
| sol_i | input | 1 | Start-of-line marker |
| line_type_i | input | 1 | Line type, captured with `sol_i` |
| ob_i | input | 1 | Sample lies in the optical-black region |
| y_o | output | 12 | Luminance, clipped at zero |
| c_o | output | 13 | Colour difference, signed |
| tag_o | output | 1 | 0: R-Y, 1: -(B-Y) |
| vld_o | output | 1 | Output strobe |

## Verification
A line start can arrive in the same cycle as a sample. That single cycle restarts the pair phase, loads the new black reference, restarts the black accumulator and captures the new line type, all while a sample is accepted. The random line generator places a black or active sample on about a third of the line starts, and also ends lines right after a closing sample or on an odd leftover. The bench model applies the new reference only to later pairs, starts the new accumulation with the black sample taken at the marker, and expects the leftover to vanish. Every emitted triple is compared against that model.

// File: rtl/mosaic_pkg.sv
package mosaic_pkg;
  parameter int PIX_W = 12;

  typedef logic [PIX_W-1:0]        pix_t;
  typedef logic signed [PIX_W:0]   chroma_t;

  // half of (a - ref) + (b - ref), clipped at zero
  function automatic pix_t luma_of(pix_t a, pix_t b, pix_t lvl);
    logic signed [PIX_W+3:0] s;
    s = $signed({4'b0, a}) + $signed({4'b0, b}) - $signed({3'b0, lvl, 1'b0});
    if (s <= 0) return '0;
    return s[PIX_W:1];
  endfunction

  // closing member minus opening member; the black level cancels
  function automatic chroma_t chroma_of(pix_t first, pix_t second);
    return $signed({1'b0, second}) - $signed({1'b0, first});
  endfunction
endpackage

// File: rtl/mos_ob_level.sv
module mos_ob_level
  import mosaic_pkg::*;
#(
  parameter int OB_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ob_take_i,
  input  pix_t smp_i,
  input  logic sol_i,
  output pix_t level_o,
  output logic load_o
);
  localparam int OB_N  = 1 << OB_LOG2;
  localparam int CNT_W = OB_LOG2 + 1;
  localparam int ACC_W = PIX_W + OB_LOG2;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  pix_t             level_q;
  logic             full;

  assign full   = (cnt_q == CNT_W'(OB_N));
  assign load_o = sol_i && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      level_q <= '0;
    end else if (sol_i) begin
      if (full) level_q <= acc_q[ACC_W-1:OB_LOG2];
      acc_q <= ob_take_i ? ACC_W'(smp_i) : '0;
      cnt_q <= ob_take_i ? CNT_W'(1) : '0;
    end else if (ob_take_i && !full) begin
      acc_q <= acc_q + ACC_W'(smp_i);
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign level_o = level_q;

  // R8: count never passes the window size
  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(OB_N));
endmodule

// File: rtl/mos_pair_track.sv
module mos_pair_track
  import mosaic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  pix_t smp_i,
  input  logic sol_i,
  input  logic line_i,
  output pix_t held_o,
  output logic close_o,
  output logic line_o
);
  logic phase_q;
  logic line_q;
  pix_t held_q;

  assign close_o = act_i && phase_q && !sol_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      line_q  <= 1'b0;
      held_q  <= '0;
    end else begin
      if (sol_i) begin
        phase_q <= act_i;
        line_q  <= line_i;
      end else if (act_i) begin
        phase_q <= !phase_q;
      end
      if (act_i && (sol_i || !phase_q)) held_q <= smp_i;
    end
  end

  assign held_o = held_q;
  assign line_o = line_q;
endmodule

// File: rtl/mos_ycc_out.sv
module mos_ycc_out
  import mosaic_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    close_i,
  input  pix_t    held_i,
  input  pix_t    smp_i,
  input  pix_t    level_i,
  input  logic    line_i,
  output pix_t    y_o,
  output chroma_t c_o,
  output logic    tag_o,
  output logic    vld_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_o   <= '0;
      c_o   <= '0;
      tag_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= close_i;
      if (close_i) begin
        y_o   <= luma_of(held_i, smp_i, level_i);
        c_o   <= chroma_of(held_i, smp_i);
        tag_o <= line_i;
      end
    end
  end
endmodule

// File: rtl/mosaic_ycc_sep.sv
module mosaic_ycc_sep
  import mosaic_pkg::*;
#(
  parameter int OB_LOG2 = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PIX_W-1:0]        smp_i,
  input  logic                    smp_vld_i,
  input  logic                    sol_i,
  input  logic                    line_type_i,
  input  logic                    ob_i,
  output logic [PIX_W-1:0]        y_o,
  output logic signed [PIX_W:0]   c_o,
  output logic                    tag_o,
  output logic                    vld_o
);
  // named internal events
  logic ob_take;
  logic act;
  logic pair_close;
  logic level_load;
  logic line_cur;
  pix_t held;
  pix_t level;

  assign ob_take = smp_vld_i && ob_i;
  assign act     = smp_vld_i && !ob_i;

  mos_ob_level #(.OB_LOG2(OB_LOG2)) u_ob (
    .clk(clk), .rst_n(rst_n), .ob_take_i(ob_take), .smp_i(smp_i),
    .sol_i(sol_i), .level_o(level), .load_o(level_load)
  );

  mos_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .act_i(act), .smp_i(smp_i), .sol_i(sol_i),
    .line_i(line_type_i), .held_o(held), .close_o(pair_close), .line_o(line_cur)
  );

  mos_ycc_out u_out (
    .clk(clk), .rst_n(rst_n), .close_i(pair_close), .held_i(held),
    .smp_i(smp_i), .level_i(level), .line_i(line_cur),
    .y_o(y_o), .c_o(c_o), .tag_o(tag_o), .vld_o(vld_o)
  );

  // R2: an output only follows an accepted active sample outside a line start
  a_r2_out_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(smp_vld_i && !ob_i && !sol_i));
  // R6: a sample taken with the line marker only opens a pair
  a_r6_no_out_after_sol: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sol_i) |-> !vld_o);
  // R7: black samples never close a pair
  a_r7_ob_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld_i && ob_i) |-> !vld_o);
  // R5: tag agrees with the line type held for the current line
  a_r5_tag_line: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (tag_o == line_cur));
  // R8: the reference moves only after a load at a line start
  a_r8_level_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(level_load));
endmodule

// File: tb/mosaic_ycc_sep_tb.sv
`timescale 1ns/1ps
module mosaic_ycc_sep_tb;
  localparam int W    = 12;
  localparam int K    = 4;
  localparam int N    = 1 << K;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] smp = '0;
  logic vld = 1'b0, sol = 1'b0, lt = 1'b0, ob = 1'b0;
  logic [W-1:0] y;
  logic signed [W:0] c;
  logic tag, ovld;

  always #4 clk = ~clk;

  mosaic_ycc_sep #(.OB_LOG2(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(vld), .sol_i(sol),
    .line_type_i(lt), .ob_i(ob), .y_o(y), .c_o(c), .tag_o(tag), .vld_o(ovld)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  int lvl_m = 0, acc_m = 0, cnt_m = 0, held_m = 0;
  bit phase_m = 0, line_m = 0;
  int exp_y[$], exp_c[$], exp_t[$];

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  function automatic int luma_ref(int a, int b, int l);
    int d;
    d = (a - l) + (b - l);
    return (d > 0) ? d / 2 : 0;
  endfunction

  task automatic drive(bit v, bit s, bit t, bit o, int val);
    @(negedge clk);
    vld = v; sol = s; lt = t; ob = o; smp = W'(val);
    if (s) begin
      if (cnt_m == N) lvl_m = acc_m / N;
      acc_m = 0; cnt_m = 0; phase_m = 0; line_m = t;
    end
    if (v && o) begin
      if (cnt_m < N) begin acc_m += val; cnt_m++; end
    end else if (v) begin
      if (!phase_m) begin held_m = val; phase_m = 1; end
      else begin
        exp_y.push_back(luma_ref(held_m, val, lvl_m));
        exp_c.push_back(val - held_m);
        exp_t.push_back(int'(line_m));
        phase_m = 0;
      end
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  // output monitor, samples after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        if (ovld) begin
          if (exp_y.size() == 0) chk(0, "R2 unexpected output", 1, 0);
          else begin
            int ey, ec, et;
            ey = exp_y.pop_front(); ec = exp_c.pop_front(); et = exp_t.pop_front();
            chk(int'(y) == ey, "R3 luma", int'(y), ey);
            chk(int'(c) == ec, "R4 chroma", int'(c), ec);
            chk(int'(tag) == et, "R5 tag", int'(tag), et);
          end
        end else if (exp_y.size() != 0) begin
          chk(0, "R2 missing output", 0, exp_y.size());
          exp_y.delete(); exp_c.delete(); exp_t.delete();
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  // one line with pairs built from random colour components
  task automatic rand_line(bit t, int n_ob, int n_act, int ob_max);
    bit sol_smp;
    sol_smp = ($urandom_range(0, 2) == 0);
    if (sol_smp && n_ob > 0) begin
      drive(1, 1, t, 1, $urandom_range(0, ob_max)); n_ob--;
    end else if (sol_smp) begin
      drive(1, 1, t, 0, $urandom_range(0, FULL));
      n_act--;
    end else drive(0, 1, t, 0, 0);
    for (int i = 0; i < n_ob; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      drive(1, 0, 0, 1, $urandom_range(0, ob_max));
    end
    for (int i = 0; i < n_act; i += 2) begin
      int g, cy, mg, ye;
      g = $urandom_range(0, 2047); cy = $urandom_range(0, 2047);
      mg = $urandom_range(0, 2047); ye = $urandom_range(0, 2047);
      if ($urandom_range(0, 3) == 0) idle();
      if ($urandom_range(0, 19) == 0) drive(1, 0, 0, 1, $urandom_range(0, ob_max)); // R7
      drive(1, 0, 0, 0, t ? (mg + cy) : (g + cy));
      if (i + 1 < n_act) begin
        if ($urandom_range(0, 4) == 0) idle();
        drive(1, 0, 0, 0, t ? (g + ye) : (mg + ye));
      end
    end
  endtask

  task automatic const_line(bit t, int n_ob, int ob_val, int a, int b, int pairs);
    drive(0, 1, t, 0, 0);
    for (int i = 0; i < n_ob; i++) drive(1, 0, 0, 1, ob_val);
    for (int i = 0; i < pairs; i++) begin
      drive(1, 0, 0, 0, a);
      drive(1, 0, 0, 0, b);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ovld == 1'b0, "R1 vld in reset", int'(ovld), 0);
    chk(y == '0, "R1 y in reset", int'(y), 0);
    chk(c == '0, "R1 c in reset", int'(c), 0);
    chk(tag == 1'b0, "R1 tag in reset", int'(tag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovld == 1'b0, "R1 vld after reset", int'(ovld), 0);

    // directed corners (R3, R4, R8)
    const_line(0, 0, 0, 0, 0, 2);                 // zero input, reference 0
    const_line(1, 0, 0, FULL, FULL, 2);           // full scale both
    const_line(0, N, 0, FULL, 0, 1);              // c = -4095
    const_line(1, N, 4000, 0, FULL, 2);           // c = +4095, then ref 4000 loaded
    const_line(0, 3, 10, 100, 200, 2);            // R8 short black run: ref stays 4000, y clips to 0
    const_line(1, N + 5, 50, FULL, FULL, 1);      // loads 4000 from the previous full run? no: prior line short
    const_line(0, N, 7, 300, 301, 2);             // uses ref 50, loads 7 later
    const_line(1, 0, 0, 5, 6, 1);                 // ref 7: y clips? (5-7)+(6-7)<0 -> 0
    // R6: odd leftover, then marker
    drive(0, 1, 0, 0, 0);
    drive(1, 0, 0, 0, 1234);
    drive(1, 0, 0, 0, 55);
    drive(1, 0, 0, 0, 999);                       // dropped
    drive(1, 1, 1, 0, 2000);                      // opens pair with marker
    drive(1, 0, 0, 0, 2500);
    idle();

    // random lines
    for (int l = 0; l < 70; l++) begin
      int sel, n_ob, ob_max;
      sel = $urandom_range(0, 5);
      n_ob = (sel < 3) ? N : (sel == 3) ? N - 1 : (sel == 4) ? N + 2 : 0;
      ob_max = ($urandom_range(0, 4) == 0) ? FULL : 400;
      rand_line(1'($urandom_range(0, 1)), n_ob, $urandom_range(2, 41), ob_max);
    end
    repeat (4) idle();
    chk(exp_y.size() == 0, "R2 pending at end", exp_y.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule